// File: doc/BRIEF.md
# Segmented Johnson-Binary Phase Accumulator

This block counts rising edges of a fast oscillator clock and presents the running total as an unsigned binary word. The word is refreshed once per rising edge of a much slower reference clock. The count is split in two. The upper bits come from a binary counter that steps once every `2^LO_W` fast cycles. The lowest `LO_W` bits are held as a Johnson pattern in a bare shift register of `2^LO_W` flops. That register takes the counter's least significant bit as its serial input. Apart from the small divider that times the counter's step, the fast domain carries only flip-flops.

On each reference edge both parts are captured. A combinational decoder placed after the capture registers turns the Johnson pattern into binary low bits. The decode delay is therefore charged only against the reference period. The default build gives an 8-bit word: a 6-bit upper counter and a 4-flop ring stepping every four fast cycles. The word is meant to feed the phase-error arithmetic of a digital frequency synthesiser.

Top module: `seg_phase_acc`

## Requirements
- R1: After a reference rising edge with reset low, `phase_word` equals, modulo 256, the number of fast rising edges that had reset low and occurred before that reference edge.
- R2: The count wraps silently: once more than 255 fast edges have elapsed since reset, the word reads the total minus a multiple of 256.
- R3: A reference rising edge that samples reset high makes `phase_word` read 0 until the next reference edge.
- R4: `phase_word` changes only on reference rising edges and holds its value between them.
- R5: The two low bits decode a legal 4-flop Johnson ring (bit 0 newest). Filling states 0001, 0011, 0111, 1111 give 0, 1, 2, 3. Draining states 1110, 1100, 1000, 0000 give 0, 1, 2, 3. The ring changes exactly one bit per fast edge, so `phase_word[1:0]` equals the count modulo 4.
- R6: The upper counter advances by one on the fast edge that ends each group of four fast cycles and holds on the other edges, so `phase_word[7:2]` equals the count divided by 4, modulo 64.
- R7: Reset sets the divider, counter and ring to a phase where the first sample after release reads exactly the number of fast edges since release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Oscillator clock whose rising edges are counted |
| ref_clk | input | 1 | Slow reference clock that samples the count |
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| phase_word | output | 8 | Sampled binary count, modulo 256 |

## Verification
The sweep runs the reference clock at three unrelated periods of about 13, 37 and 100 fast cycles. Sample points then land on every residue of the ring and repeatedly cross the 255-to-0 wrap. A decoder with a wrong entry, or a ring reset to the wrong phase, reads one off at particular low residues or right after reset release. An upper counter that steps at the wrong divider phase shows as a carry that is one sample early or late in the top six bits. A reset that misses the capture registers, or a capture that is not held, shows as a nonzero word during reset or a word that moves between reference edges.

// File: rtl/seg_acc_pkg.sv
package seg_acc_pkg;

    localparam int unsigned MAX_RING = 32;

    typedef enum logic {
        PH_DRAIN = 1'b0,
        PH_FILL  = 1'b1
    } ring_phase_e;

    function automatic int unsigned ones_in(input logic [MAX_RING-1:0] v,
                                            input int unsigned len);
        int unsigned n;
        n = 0;
        for (int unsigned i = 0; i < MAX_RING; i++) begin
            if (i < len && v[i]) n++;
        end
        return n;
    endfunction

    // Johnson ring to binary: in the filling half the run of ones grows from bit 0,
    // in the draining half the zeros advance from bit 0.
    function automatic int unsigned ring_to_bin(input logic [MAX_RING-1:0] v,
                                                input int unsigned len);
        ring_phase_e ph;
        int unsigned k;
        ph = ring_phase_e'(v[0]);
        k  = ones_in(v, len);
        if (ph == PH_FILL) return (k == 0) ? 0 : k - 1;
        return (k >= len) ? 0 : len - 1 - k;
    endfunction

    // Draining state that decodes to zero: every bit set except the newest.
    function automatic logic [MAX_RING-1:0] ring_reset_pattern(input int unsigned len);
        logic [MAX_RING-1:0] p;
        p = '0;
        for (int unsigned i = 1; i < MAX_RING; i++) begin
            if (i < len) p[i] = 1'b1;
        end
        return p;
    endfunction

    // A Johnson pattern has at most one boundary between adjacent bits.
    function automatic logic ring_is_legal(input logic [MAX_RING-1:0] v,
                                           input int unsigned len);
        int unsigned t;
        t = 0;
        for (int unsigned i = 0; i + 1 < MAX_RING; i++) begin
            if (i + 1 < len && v[i] != v[i+1]) t++;
        end
        return t <= 1;
    endfunction

endpackage

// File: rtl/acc_fast_divider.sv
module acc_fast_divider #(
    parameter int unsigned LO_W = 2
) (
    input  logic            fast_clk,
    input  logic            rst,
    output logic [LO_W-1:0] div_phase,
    output logic            step_en
);
    // Reset phase 1 aligns the counter step with the ring reset pattern.
    localparam logic [LO_W-1:0] PHASE_RST = LO_W'(1);

    always_ff @(posedge fast_clk) begin
        if (rst) div_phase <= PHASE_RST;
        else     div_phase <= div_phase + LO_W'(1);
    end

    assign step_en = &div_phase;
endmodule

// File: rtl/acc_upper_counter.sv
module acc_upper_counter #(
    parameter int unsigned HI_W = 6
) (
    input  logic            fast_clk,
    input  logic            rst,
    input  logic            step_en,
    output logic [HI_W-1:0] upper,
    output logic [HI_W-1:0] upper_lag
);
    always_ff @(posedge fast_clk) begin
        if (rst)          upper <= '0;
        else if (step_en) upper <= upper + HI_W'(1);
    end

    // Bare retiming stage: the ring sees the counter LSB one edge late,
    // so the sampled upper value is delayed to match.
    always_ff @(posedge fast_clk) begin
        if (rst) upper_lag <= '0;
        else     upper_lag <= upper;
    end
endmodule

// File: rtl/acc_johnson_shifter.sv
module acc_johnson_shifter
    import seg_acc_pkg::*;
#(
    parameter int unsigned RING_LEN = 4
) (
    input  logic                fast_clk,
    input  logic                rst,
    input  logic                serial_in,
    output logic [RING_LEN-1:0] ring
);
    localparam logic [RING_LEN-1:0] RING_RST = RING_LEN'(ring_reset_pattern(RING_LEN));

    always_ff @(posedge fast_clk) begin
        if (rst) ring[0] <= RING_RST[0];
        else     ring[0] <= serial_in;
    end

    for (genvar s = 1; s < RING_LEN; s++) begin : g_stage
        always_ff @(posedge fast_clk) begin
            if (rst) ring[s] <= RING_RST[s];
            else     ring[s] <= ring[s-1];
        end
    end
endmodule

// File: rtl/acc_ref_sampler.sv
module acc_ref_sampler
    import seg_acc_pkg::*;
#(
    parameter int unsigned HI_W     = 6,
    parameter int unsigned LO_W     = 2,
    parameter int unsigned RING_LEN = 4
) (
    input  logic                 ref_clk,
    input  logic                 rst,
    input  logic [HI_W-1:0]      upper_in,
    input  logic [RING_LEN-1:0]  ring_in,
    output logic [RING_LEN-1:0]  ring_q,
    output logic [HI_W+LO_W-1:0] word
);
    localparam logic [RING_LEN-1:0] RING_RST = RING_LEN'(ring_reset_pattern(RING_LEN));

    logic [HI_W-1:0] upper_q;
    logic [LO_W-1:0] low_bin;

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            upper_q <= '0;
            ring_q  <= RING_RST;
        end else begin
            upper_q <= upper_in;
            ring_q  <= ring_in;
        end
    end

    // Decoder lives in the slow domain only.
    always_comb begin
        low_bin = LO_W'(ring_to_bin(MAX_RING'(ring_q), RING_LEN));
    end

    assign word = {upper_q, low_bin};
endmodule

// File: rtl/seg_phase_acc.sv
module seg_phase_acc #(
    parameter int unsigned HI_W = 6,
    parameter int unsigned LO_W = 2
) (
    input  logic                 fast_clk,
    input  logic                 ref_clk,
    input  logic                 rst,
    output logic [HI_W+LO_W-1:0] phase_word
);
    localparam int unsigned RING_LEN = 1 << LO_W;

    logic [LO_W-1:0]     div_phase;
    logic                step_en;
    logic [HI_W-1:0]     upper;
    logic [HI_W-1:0]     upper_lag;
    logic [RING_LEN-1:0] ring;
    logic [RING_LEN-1:0] ring_q;

    acc_fast_divider #(.LO_W(LO_W)) u_div (
        .fast_clk  (fast_clk),
        .rst       (rst),
        .div_phase (div_phase),
        .step_en   (step_en)
    );

    acc_upper_counter #(.HI_W(HI_W)) u_upper (
        .fast_clk  (fast_clk),
        .rst       (rst),
        .step_en   (step_en),
        .upper     (upper),
        .upper_lag (upper_lag)
    );

    acc_johnson_shifter #(.RING_LEN(RING_LEN)) u_ring (
        .fast_clk  (fast_clk),
        .rst       (rst),
        .serial_in (upper[0]),
        .ring      (ring)
    );

    acc_ref_sampler #(.HI_W(HI_W), .LO_W(LO_W), .RING_LEN(RING_LEN)) u_smp (
        .ref_clk  (ref_clk),
        .rst      (rst),
        .upper_in (upper_lag),
        .ring_in  (ring),
        .ring_q   (ring_q),
        .word     (phase_word)
    );
endmodule

// File: rtl/seg_phase_acc_chk.sv
module seg_phase_acc_chk
    import seg_acc_pkg::*;
#(
    parameter int unsigned HI_W = 6,
    parameter int unsigned LO_W = 2
) (
    input logic                      fast_clk,
    input logic                      ref_clk,
    input logic                      rst,
    input logic [LO_W-1:0]           div_phase,
    input logic [HI_W-1:0]           upper,
    input logic [(1 << LO_W)-1:0]    ring,
    input logic [(1 << LO_W)-1:0]    ring_q
);
    localparam int unsigned RING_LEN = 1 << LO_W;
    localparam logic [LO_W-1:0] LAST_PHASE = LO_W'(RING_LEN - 1);

    // R6: counter steps on the last divider phase
    p_upper_step_r6: assert property (@(posedge fast_clk) disable iff (rst)
        (div_phase == LAST_PHASE) |=> (upper == $past(upper) + HI_W'(1)));

    // R6: counter holds on all other phases
    p_upper_hold_r6: assert property (@(posedge fast_clk) disable iff (rst)
        (div_phase != LAST_PHASE) |=> $stable(upper));

    // R5: the ring moves by exactly one bit per fast edge
    p_ring_step_r5: assert property (@(posedge fast_clk) disable iff (rst)
        !$past(rst) |-> ($countones(ring ^ $past(ring)) == 1));

    // R5: the ring always holds a legal Johnson pattern
    p_ring_legal_r5: assert property (@(posedge fast_clk) disable iff (rst)
        ring_is_legal(MAX_RING'(ring), RING_LEN));

    // R5: the captured pattern fed to the decoder is legal
    p_sample_legal_r5: assert property (@(posedge ref_clk) disable iff (rst)
        ring_is_legal(MAX_RING'(ring_q), RING_LEN));
endmodule

bind seg_phase_acc seg_phase_acc_chk #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
    .fast_clk  (fast_clk),
    .ref_clk   (ref_clk),
    .rst       (rst),
    .div_phase (div_phase),
    .upper     (upper),
    .ring      (ring),
    .ring_q    (ring_q)
);

// File: tb/seg_phase_acc_test.sv
module seg_phase_acc_test;
    localparam int HI_W = 6;
    localparam int LO_W = 2;

    logic       fast_clk = 1'b0;
    logic       ref_clk  = 1'b0;
    logic       rst      = 1'b1;
    logic [7:0] phase_word;

    int          ref_half = 373;   // odd: reference edges never meet fast edges
    int          vectors  = 0;
    int          fails    = 0;
    int unsigned edge_cnt = 0;
    int unsigned exp_full = 0;
    logic        exp_rst  = 1'b1;
    logic [3:0]  seen_low = '0;
    int          wraps    = 0;
    logic [7:0]  prev_word = '0;
    logic        prev_ok   = 1'b0;
    logic        fresh     = 1'b0;

    seg_phase_acc #(.HI_W(HI_W), .LO_W(LO_W)) uut (
        .fast_clk   (fast_clk),
        .ref_clk    (ref_clk),
        .rst        (rst),
        .phase_word (phase_word)
    );

    initial forever #10 fast_clk = ~fast_clk;

    initial begin
        #3;
        forever begin
            ref_clk = 1'b1; #ref_half;
            ref_clk = 1'b0; #ref_half;
        end
    end

    // Reference model: fast edges with reset low since the last reset.
    always @(posedge fast_clk) begin
        if (rst) edge_cnt <= 0;
        else     edge_cnt <= edge_cnt + 1;
    end

    always @(posedge ref_clk) begin
        exp_full <= edge_cnt;
        exp_rst  <= rst;
    end

    task automatic sample_and_check();
        logic [7:0] held;
        logic [7:0] exp_word;
        @(negedge ref_clk); #1;
        exp_word = exp_rst ? 8'd0 : 8'(exp_full % 256);
        vectors++;
        if (exp_rst) begin
            if (phase_word !== 8'd0) begin
                fails++;
                $display("FAIL R3 reset word actual=%0d expected=0", phase_word);
            end
            prev_ok = 1'b0;
        end else begin
            if (phase_word !== exp_word) begin
                fails++;
                if (fresh)
                    $display("FAIL R7 first sample actual=%0d expected=%0d", phase_word, exp_word);
                else if (exp_full >= 256)
                    $display("FAIL R2 wrapped word actual=%0d expected=%0d", phase_word, exp_word);
                else
                    $display("FAIL R1 word actual=%0d expected=%0d", phase_word, exp_word);
            end
            fresh = 1'b0;
            vectors++;
            if (phase_word[1:0] !== 2'(exp_full % 4)) begin
                fails++;
                $display("FAIL R5 low bits actual=%0d expected=%0d", phase_word[1:0], exp_full % 4);
            end
            vectors++;
            if (phase_word[7:2] !== 6'((exp_full / 4) % 64)) begin
                fails++;
                $display("FAIL R6 upper bits actual=%0d expected=%0d", phase_word[7:2], (exp_full / 4) % 64);
            end
            seen_low[phase_word[1:0]] = 1'b1;
            if (prev_ok && phase_word < prev_word) wraps++;
            prev_word = phase_word;
            prev_ok   = 1'b1;
        end
        held = phase_word;
        #(ref_half - 3);
        vectors++;
        if (phase_word !== held) begin
            fails++;
            $display("FAIL R4 word moved between edges actual=%0d expected=%0d", phase_word, held);
        end
    endtask

    task automatic release_reset();
        @(negedge fast_clk);
        rst   = 1'b0;
        fresh = 1'b1;
    endtask

    initial begin
        // R3: reset state
        repeat (2) sample_and_check();
        release_reset();
        repeat (400) sample_and_check();

        // R3 again mid-run, then a faster reference
        @(negedge fast_clk);
        rst      = 1'b1;
        ref_half = 131;
        repeat (3) sample_and_check();
        release_reset();
        repeat (600) sample_and_check();

        @(negedge fast_clk);
        rst      = 1'b1;
        ref_half = 1001;
        repeat (2) sample_and_check();
        release_reset();
        repeat (100) sample_and_check();

        vectors++;
        if (seen_low !== 4'hF) begin
            fails++;
            $display("FAIL R5 low residues seen actual=%b expected=1111", seen_low);
        end
        vectors++;
        if (wraps == 0) begin
            fails++;
            $display("FAIL R2 wrap events actual=%0d expected>0", wraps);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #2_500_000;
        fails++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule